// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches 24 general-purpose input pins, grouped into three banks of eight. It turns activity on them into interrupt status bits and combines those bits into one interrupt line for the host. The pins first pass through a synchroniser. After that, each pin is judged against its own trigger setting. A pin can be edge sensitive on a chosen edge, edge sensitive on either edge, or level sensitive at a chosen level. Every trigger event sets a raw status bit.

A per-pin enable passes the raw bit into a masked status bit. The host line is high whenever any masked bit is set. The host works through a byte-wide register port: it writes trigger settings, reads raw and masked status, and acknowledges events by writing ones to a per-bank clear address. The three masked status bytes sit at consecutive addresses, so a handler can fetch them in one three-byte burst.

Top module: `gpioIrqDetect`

## Requirements
- R1: After reset every configuration bit, every raw and masked status bit and `irqOut` are 0, so all pins are set to falling-edge sensing with the interrupt disabled.
- R2: A pin in edge mode (sense bit 0) with polarity 0 and both-edge bit 0 sets its raw status bit on a 1-to-0 transition only.
- R3: A pin in edge mode with polarity 1 and both-edge bit 0 sets its raw status bit on a 0-to-1 transition only.
- R4: A pin in edge mode with its both-edge bit at 1 sets its raw status bit on any transition, whatever its polarity bit holds.
- R5: A pin with sense bit 1 is level sensitive. It sets its raw status bit in every cycle its synchronised input is high (polarity 1) or low (polarity 0). Its both-edge bit has no effect.
- R6: The raw status is recorded whether or not the pin is enabled. The masked status byte of bank b, read at address 0x18+b, equals that bank's raw status AND enable.
- R7: `irqOut` is 1 exactly when at least one masked status bit of any bank is 1.
- R8: Writing a byte to the clear address of bank b (0x1C+b) clears each raw status bit of that bank whose data bit is 1. It leaves every other bit unchanged.
- R9: A level-sensitive pin whose level is still active sets its raw status bit again in the cycle after a clear.
- R10: When a clear write and a new trigger event for the same pin take effect on the same clock edge, the raw status bit ends up set.
- R11: With the default two synchroniser stages, a pin change driven between edges shows in the raw status after the third rising clock edge, and not after the second.
- R12: Bank b holds its registers at base 8*b, at these offsets: both-edge +0, polarity +1, sense +2, enable +3, raw status +4 (read only). Configuration registers read back what was written. Writes to status addresses or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | 24 | Asynchronous pin inputs; bit 8*b+i is pin i of bank b |
| busWrEn | input | 1 | Write strobe for the register port |
| busAddr | input | 6 | Register address |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Combined interrupt to the host |

## Verification
Two things can land on the same clock edge: the host's write-one-to-clear acknowledge and a fresh trigger event on the pin being acknowledged. The bench provokes this directly. It raises a pin configured for rising edges, then times a clear write to that pin's bank so the write commits on exactly the edge where the synchronised rising edge reaches the status register. The bit must survive. A clear one cycle later must remove it. Randomised traffic that mixes pin toggles, configuration writes and clears then keeps re-judging status against a bench model of the trigger rules.

// File: rtl/gpioirq_pkg.sv
package gpioirq_pkg;
  localparam int BANKS       = 3;
  localparam int BANK_W      = 8;
  localparam int PINS        = BANKS * BANK_W;
  localparam int ADDR_W      = 6;
  localparam int BANK_STRIDE = 8;
  // per-bank register offsets
  localparam int OFS_BOTH    = 0;
  localparam int OFS_POL     = 1;
  localparam int OFS_SENSE   = 2;
  localparam int OFS_EN      = 3;
  localparam int OFS_RAW     = 4;
  // bank-contiguous windows
  localparam int MASKED_BASE = 24;
  localparam int CLEAR_BASE  = 28;

  typedef struct packed {
    logic [BANKS-1:0]  wrBoth;
    logic [BANKS-1:0]  wrPol;
    logic [BANKS-1:0]  wrSense;
    logic [BANKS-1:0]  wrEnable;
    logic [BANKS-1:0]  wrClear;
    logic [BANK_W-1:0] wData;
  } ctrlStrobes_t;
endpackage

// File: rtl/pinSync.sv
module pinSync #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/regCtl.sv
module regCtl
  import gpioirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] wData,
  input  logic [PINS-1:0]   bothCfg,
  input  logic [PINS-1:0]   polCfg,
  input  logic [PINS-1:0]   senseCfg,
  input  logic [PINS-1:0]   enCfg,
  input  logic [PINS-1:0]   rawSt,
  input  logic [PINS-1:0]   maskedSt,
  output ctrlStrobes_t      strobes,
  output logic [BANK_W-1:0] rData
);
  logic [BANKS-1:0] hitBoth, hitPol, hitSense, hitEn, hitClr;

  for (genvar b = 0; b < BANKS; b++) begin : g_dec
    localparam logic [ADDR_W-1:0] A_BOTH  = ADDR_W'(b * BANK_STRIDE + OFS_BOTH);
    localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(b * BANK_STRIDE + OFS_POL);
    localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(b * BANK_STRIDE + OFS_SENSE);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(b * BANK_STRIDE + OFS_EN);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(CLEAR_BASE + b);
    assign hitBoth[b]  = (addr == A_BOTH);
    assign hitPol[b]   = (addr == A_POL);
    assign hitSense[b] = (addr == A_SENSE);
    assign hitEn[b]    = (addr == A_EN);
    assign hitClr[b]   = (addr == A_CLR);
  end

  always_comb begin
    strobes.wrBoth   = wrEn ? hitBoth  : '0;
    strobes.wrPol    = wrEn ? hitPol   : '0;
    strobes.wrSense  = wrEn ? hitSense : '0;
    strobes.wrEnable = wrEn ? hitEn    : '0;
    strobes.wrClear  = wrEn ? hitClr   : '0;
    strobes.wData    = wData;
  end

  always_comb begin
    rData = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (addr == ADDR_W'(b * BANK_STRIDE + OFS_BOTH))  rData = bothCfg[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(b * BANK_STRIDE + OFS_POL))   rData = polCfg[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(b * BANK_STRIDE + OFS_SENSE)) rData = senseCfg[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(b * BANK_STRIDE + OFS_EN))    rData = enCfg[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(b * BANK_STRIDE + OFS_RAW))   rData = rawSt[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(MASKED_BASE + b))             rData = maskedSt[b*BANK_W +: BANK_W];
    end
  end

  // R12
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ({strobes.wrBoth, strobes.wrPol, strobes.wrSense,
                strobes.wrEnable, strobes.wrClear} == '0));

  // R12
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrBoth, strobes.wrPol, strobes.wrSense,
              strobes.wrEnable, strobes.wrClear}));
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import gpioirq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] syncPins,
  input  ctrlStrobes_t    strobes,
  output logic [PINS-1:0] bothCfg,
  output logic [PINS-1:0] polCfg,
  output logic [PINS-1:0] senseCfg,
  output logic [PINS-1:0] enCfg,
  output logic [PINS-1:0] rawSt,
  output logic [PINS-1:0] maskedSt,
  output logic            irq
);
  logic [PINS-1:0] prevPins;
  logic [PINS-1:0] evtVec;
  logic [PINS-1:0] clrMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPins <= '0;
    else       prevPins <= syncPins;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bothCfg[b*BANK_W +: BANK_W]  <= '0;
        polCfg[b*BANK_W +: BANK_W]   <= '0;
        senseCfg[b*BANK_W +: BANK_W] <= '0;
        enCfg[b*BANK_W +: BANK_W]    <= '0;
      end else begin
        if (strobes.wrBoth[b])   bothCfg[b*BANK_W +: BANK_W]  <= strobes.wData;
        if (strobes.wrPol[b])    polCfg[b*BANK_W +: BANK_W]   <= strobes.wData;
        if (strobes.wrSense[b])  senseCfg[b*BANK_W +: BANK_W] <= strobes.wData;
        if (strobes.wrEnable[b]) enCfg[b*BANK_W +: BANK_W]    <= strobes.wData;
      end
    end
    assign clrMask[b*BANK_W +: BANK_W] = strobes.wrClear[b] ? strobes.wData : '0;
  end

  // trigger qualification per pin
  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      if (senseCfg[i])
        evtVec[i] = polCfg[i] ? syncPins[i] : ~syncPins[i];
      else if (bothCfg[i])
        evtVec[i] = syncPins[i] ^ prevPins[i];
      else if (polCfg[i])
        evtVec[i] = syncPins[i] & ~prevPins[i];
      else
        evtVec[i] = ~syncPins[i] & prevPins[i];
    end
  end

  // a new event outranks a clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawSt <= '0;
    else       rawSt <= (rawSt & ~clrMask) | evtVec;
  end

  assign maskedSt = rawSt & enCfg;
  assign irq      = |maskedSt;

  // R8
  clear_applies_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrMask & ~evtVec)) |=> ((rawSt & $past(clrMask & ~evtVec)) == '0));

  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((rawSt & $past(evtVec)) == $past(evtVec)));

  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawSt & ~$past(rawSt) & ~$past(evtVec)) == '0));

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrBoth == '0 && strobes.wrPol == '0 && strobes.wrSense == '0
     && strobes.wrEnable == '0) |=> ($stable(bothCfg) && $stable(polCfg)
     && $stable(senseCfg) && $stable(enCfg)));
endmodule

// File: rtl/gpioIrqDetect.sv
module gpioIrqDetect
  import gpioirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinIn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BANK_W-1:0] busWData,
  output logic [BANK_W-1:0] busRData,
  output logic              irqOut
);
  ctrlStrobes_t    strobes;
  logic [PINS-1:0] syncPins;
  logic [PINS-1:0] bothCfg, polCfg, senseCfg, enCfg, rawSt, maskedSt;

  pinSync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .d(pinIn), .q(syncPins)
  );

  regCtl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr), .wData(busWData),
    .bothCfg(bothCfg), .polCfg(polCfg), .senseCfg(senseCfg), .enCfg(enCfg),
    .rawSt(rawSt), .maskedSt(maskedSt), .strobes(strobes), .rData(busRData)
  );

  irqDatapath u_dp (
    .clk(clk), .rstN(rstN), .syncPins(syncPins), .strobes(strobes),
    .bothCfg(bothCfg), .polCfg(polCfg), .senseCfg(senseCfg), .enCfg(enCfg),
    .rawSt(rawSt), .maskedSt(maskedSt), .irq(irqOut)
  );

  // R7
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskedSt != '0));
endmodule

// File: tb/sim_gpioIrqDetect.sv
`timescale 1ns/1ps
module sim_gpioIrqDetect;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] pinIn = '0;
  logic        busWrEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [7:0]  busWData = '0;
  logic [7:0]  busRData;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [23:0] mBoth = '0, mPol = '0, mSense = '0, mEn = '0, mRaw = '0, curPins = '0;

  always #4 clk = ~clk;

  gpioIrqDetect u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRData;
  endtask

  function automatic logic evtBit(input logic o, input logic n, input logic bo,
                                  input logic po, input logic se);
    if (se) return po ? n : ~n;
    if (bo) return o != n;
    return po ? (!o && n) : (o && !n);
  endfunction

  function automatic logic [23:0] lvlActive(input logic [23:0] p);
    return mSense & ~(mPol ^ p);
  endfunction

  task automatic checkAll(input string rawTag);
    logic [7:0] v;
    for (int b = 0; b < 3; b++) begin
      busRead(6'(b*8+4), v);
      check(rawTag, v, mRaw[b*8 +: 8]);
      busRead(6'(24+b), v);
      check("R6 masked", v, mRaw[b*8 +: 8] & mEn[b*8 +: 8]);
    end
    check("R7 irq", {7'd0, irqOut}, {7'd0, |(mRaw & mEn)});
  endtask

  initial begin
    #(8*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    for (int b = 0; b < 3; b++) begin
      for (int r = 0; r < 5; r++) begin
        busRead(6'(b*8+r), v);
        check("R1 reset reg", v, 8'h00);
      end
      busRead(6'(24+b), v);
      check("R1 reset masked", v, 8'h00);
    end
    check("R1 reset irq", {7'd0, irqOut}, 8'h00);

    // R11 latency, pin0 rising edge, enabled
    busWrite(6'd1, 8'h01);
    busWrite(6'd3, 8'h01);
    @(negedge clk); pinIn[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); busRead(6'd4, v);
    check("R11 not yet after 2 edges", v, 8'h00);
    @(negedge clk); busRead(6'd4, v);
    check("R11 set after 3 edges", v, 8'h01);
    check("R7 irq high", {7'd0, irqOut}, 8'h01);
    busWrite(6'd28, 8'h01);
    busRead(6'd4, v);
    check("R8 cleared", v, 8'h00);
    check("R7 irq low", {7'd0, irqOut}, 8'h00);

    // R12 writes to status and unmapped addresses ignored
    busWrite(6'd4, 8'hFF);
    busWrite(6'd24, 8'hFF);
    busWrite(6'd63, 8'hFF);
    busRead(6'd4, v);  check("R12 raw unwritable", v, 8'h00);
    busRead(6'd24, v); check("R12 masked unwritable", v, 8'h00);
    busRead(6'd1, v);  check("R12 cfg readback", v, 8'h01);
    busRead(6'd0, v);  check("R12 unmapped no effect", v, 8'h00);

    // R10 clear and event on the same edge
    @(negedge clk); pinIn[0] = 1'b0;
    repeat (5) @(negedge clk);
    busWrite(6'd28, 8'hFF);
    @(negedge clk); pinIn[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); busAddr = 6'd28; busWData = 8'h01; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    busRead(6'd4, v);
    check("R10 event survives clear", v, 8'h01);
    busWrite(6'd28, 8'h01);
    busRead(6'd4, v);
    check("R10 later clear removes", v, 8'h00);

    // back to a known state for the random phase
    busWrite(6'd1, 8'h00);
    busWrite(6'd3, 8'h00);
    @(negedge clk); pinIn = '0;
    repeat (5) @(negedge clk);
    for (int b = 0; b < 3; b++) busWrite(6'(28+b), 8'hFF);
    repeat (2) @(negedge clk);
    mRaw = '0; curPins = '0;
    checkAll("R1 clean start");

    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 5);
      if (op < 2) begin
        logic [23:0] np;
        np = 24'($urandom);
        for (int i = 0; i < 24; i++)
          if (evtBit(curPins[i], np[i], mBoth[i], mPol[i], mSense[i])) mRaw[i] = 1'b1;
        @(negedge clk); pinIn = np; curPins = np;
        repeat (5) @(negedge clk);
        checkAll("R2/R3/R4/R5 raw after pin change");
      end else if (op < 4) begin
        int b, r;
        logic [7:0] d;
        b = int'($urandom % 3); r = int'($urandom % 4); d = 8'($urandom);
        busWrite(6'(b*8+r), d);
        case (r)
          0: mBoth[b*8 +: 8] = d;
          1: mPol[b*8 +: 8] = d;
          2: mSense[b*8 +: 8] = d;
          default: mEn[b*8 +: 8] = d;
        endcase
        mRaw = mRaw | lvlActive(curPins);
        repeat (4) @(negedge clk);
        checkAll("R5/R12 raw after config write");
      end else begin
        int b;
        logic [7:0] d;
        b = int'($urandom % 3); d = 8'($urandom);
        busWrite(6'(28+b), d);
        mRaw[b*8 +: 8] = mRaw[b*8 +: 8] & ~d;
        mRaw = mRaw | lvlActive(curPins);
        repeat (4) @(negedge clk);
        checkAll("R8/R9 raw after clear");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule